// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 peripheral interrupt lines and offers one request at a time to a processor, together with the identifier of the source it chose. Software programs it through a small synchronous register port. Each source has an enable bit, a pending bit and a 3-bit priority. A rising edge on a line, or a software write, sets the source's pending bit. The controller chooses the best eligible pending source and raises `irq_req` with `irq_id`. The processor accepts the offer with `irq_ack` and closes the handler with `irq_eoi`.

A grouping field decides how many of the three priority bits are used for preemption. Accepted handlers are pushed onto an internal active stack. While a handler is active, only a source whose group value is strictly lower than the group value of the innermost active handler can be offered. A base mask and a global gate can suppress requests without altering the per-source state.

Control is a three-state machine:
- IDLE: no offer is made. IDLE moves to OFFER when an eligible winner exists.
- OFFER: `irq_req` is high. The offered identifier follows the current winner. OFFER moves to SETTLE when the offer is accepted, and back to IDLE when no winner is left.
- SETTLE: a one-cycle gap after acceptance. SETTLE always moves to IDLE.

Register map (word addresses):

| Address | Contents |
|---|---|
| 0x00+w | enable-set bank |
| 0x08+w | enable-clear bank |
| 0x10+w | pend-set bank |
| 0x18+w | pend-clear bank |
| 0x20+n/4 | priority words |
| 0x40 | grouping |
| 0x41 | base mask |
| 0x42 | gate |

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, every enable and pending bit is 0, the gate is closed (reads 0) and the grouping value is 0.
- R2: Source n maps to word n/32, bit n mod 32 of each bank. Writing 1 to a bit in the enable-set bank (0x00+w) enables that source. Writing 1 to a bit in the enable-clear bank (0x08+w) disables it. Bits written as 0 change nothing. Both banks read back the current enables.
- R3: Writing 1 to a bit in the pend-set bank (0x10+w) pends a source, and so does a rising edge on its `src_irq` line. Writing 1 to a bit in the pend-clear bank (0x18+w) discards an unserviced request. Both banks read back the current pending bits.
- R4: The priority of source n sits in word 0x20+n/4, byte lane n mod 4 (bits 8*(n mod 4)+7 down to 8*(n mod 4)). Only the top 3 bits of each byte are stored, and the lower 5 bits read back as 0.
- R5: Only sources that are enabled and pending are offered. The lowest 3-bit priority value wins, and ties go to the lowest source number.
- R6: Base mask (0x41) takes its top 3 bits. A value of 0 there disables masking. Any other value blocks every source whose priority is greater than or equal to it. The lower 5 bits read back as 0.
- R7: Grouping (0x40, bits 2:0) changes only when bits 31:16 of the write carry 16'h05FA. Reads return 16'hFA05 in bits 31:16.
- R8: Gate (0x42, bit 0) at 0 keeps `irq_req` low and leaves enables and pending bits unchanged.
- R9: `irq_ack` during an offer clears the pending bit of the offered source, drops `irq_req` for at least one cycle, and makes the source's group value the innermost active level.
- R10: A grouping value k keeps the top min(k,3) priority bits as the group value. Grouping settings 3 through 7 behave alike. While a handler is active, a source is offered only when its group value is strictly lower than the innermost active group value. Sources that differ only in sub-priority bits do not preempt.
- R11: `irq_eoi` removes the innermost active level. A source that was held back is then offered on the second clock edge after the `irq_eoi` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; `reg_rdata` is valid after the next edge |
| reg_rdata | output | 32 | Registered read data |
| src_irq | input | NUM_SRC | Peripheral interrupt lines, pended on a rising edge |
| irq_req | output | 1 | Request to the processor |
| irq_id | output | $clog2(NUM_SRC) | Identifier of the offered source |
| irq_ack | input | 1 | Processor accepts the offer |
| irq_eoi | input | 1 | Processor ends the innermost handler |

## Verification
- A register write takes effect on its own edge, and `irq_req`/`irq_id` follow on the next edge. The bench therefore samples one falling edge after the write task returns.
- Read data is registered and is due one edge after the read strobe.
- After an accepted `irq_ack`, the request is low at the very next falling edge.
- After `irq_eoi`, a held-back source appears one edge later than the pop, and the bench waits exactly that extra cycle before checking.
- A source edge on `src_irq` needs two edges to reach `irq_req`: one to pend and one for the state machine.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    localparam int          ADDR_W  = 7;
    localparam logic [6:0]  A_EN_SET = 7'h00;
    localparam logic [6:0]  A_EN_CLR = 7'h08;
    localparam logic [6:0]  A_PD_SET = 7'h10;
    localparam logic [6:0]  A_PD_CLR = 7'h18;
    localparam logic [6:0]  A_PRIO   = 7'h20;
    localparam logic [6:0]  A_GROUP  = 7'h40;
    localparam logic [6:0]  A_MASK   = 7'h41;
    localparam logic [6:0]  A_GATE   = 7'h42;
    localparam logic [15:0] KEY_WR   = 16'h05FA;
    localparam logic [15:0] KEY_RD   = 16'hFA05;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OFFER  = 2'd1,
        ST_SETTLE = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PB      = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    input  logic [NUM_SRC-1:0]         src_irq,
    input  logic                       ack_clr,
    input  logic [$clog2(NUM_SRC)-1:0] ack_id,
    output logic [NUM_SRC-1:0]         en_o,
    output logic [NUM_SRC-1:0]         pend_o,
    output logic [NUM_SRC-1:0][PB-1:0] prio_o,
    output logic [2:0]                 group_o,
    output logic [PB-1:0]              mask_o,
    output logic                       gate_o
);
    localparam int IDW = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]         en_q, pend_q, line_q;
    logic [NUM_SRC-1:0][PB-1:0] prio_q;
    logic [2:0]                 group_q;
    logic [PB-1:0]              mask_q;
    logic                       gate_q;
    logic [NUM_SRC-1:0]         en_set_v, en_clr_v, pd_set_v, pd_clr_v, ack_v, prio_wr_v;
    logic [31:0]                rd_v;

    // per-source strobes decoded from the bank word and bit
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            en_set_v[i]  = wr_en && addr == A_EN_SET + ADDR_W'(i / 32) && wdata[i % 32];
            en_clr_v[i]  = wr_en && addr == A_EN_CLR + ADDR_W'(i / 32) && wdata[i % 32];
            pd_set_v[i]  = wr_en && addr == A_PD_SET + ADDR_W'(i / 32) && wdata[i % 32];
            pd_clr_v[i]  = wr_en && addr == A_PD_CLR + ADDR_W'(i / 32) && wdata[i % 32];
            prio_wr_v[i] = wr_en && addr == A_PRIO + ADDR_W'(i / 4);
            ack_v[i]     = ack_clr && ack_id == IDW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            pend_q  <= '0;
            line_q  <= '0;
            prio_q  <= '0;
            group_q <= '0;
            mask_q  <= '0;
            gate_q  <= 1'b0;
        end else begin
            line_q <= src_irq;
            en_q   <= (en_q | en_set_v) & ~en_clr_v;
            pend_q <= (pend_q | pd_set_v | (src_irq & ~line_q)) & ~pd_clr_v & ~ack_v;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (prio_wr_v[i]) prio_q[i] <= wdata[8*(i%4)+7 -: PB];
            end
            if (wr_en && addr == A_GROUP && wdata[31:16] == KEY_WR) group_q <= wdata[2:0];
            if (wr_en && addr == A_MASK) mask_q <= wdata[7 -: PB];
            if (wr_en && addr == A_GATE) gate_q <= wdata[0];
        end
    end

    always_comb begin
        rd_v = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (addr == A_EN_SET + ADDR_W'(i / 32) || addr == A_EN_CLR + ADDR_W'(i / 32))
                rd_v[i % 32] = en_q[i];
            if (addr == A_PD_SET + ADDR_W'(i / 32) || addr == A_PD_CLR + ADDR_W'(i / 32))
                rd_v[i % 32] = pend_q[i];
            if (addr == A_PRIO + ADDR_W'(i / 4))
                rd_v[8*(i%4)+7 -: PB] = prio_q[i];
        end
        if (addr == A_GROUP) rd_v = {KEY_RD, 13'd0, group_q};
        if (addr == A_MASK)  rd_v[7 -: PB] = mask_q;
        if (addr == A_GATE)  rd_v[0] = gate_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_v;
    end

    assign en_o    = en_q;
    assign pend_o  = pend_q;
    assign prio_o  = prio_q;
    assign group_o = group_q;
    assign mask_o  = mask_q;
    assign gate_o  = gate_q;

    // R7: a write without the key leaves the grouping untouched
    a_r7_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_GROUP && wdata[31:16] != KEY_WR) |=> $stable(group_q));
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
    parameter int NUM_SRC = 64,
    parameter int PB      = 3
) (
    input  logic [NUM_SRC-1:0]         en_i,
    input  logic [NUM_SRC-1:0]         pend_i,
    input  logic [NUM_SRC-1:0][PB-1:0] prio_i,
    input  logic [2:0]                 group_i,
    input  logic [PB-1:0]              mask_i,
    input  logic                       gate_i,
    input  logic                       act_valid_i,
    input  logic [PB-1:0]              act_grp_i,
    output logic                       win_valid,
    output logic [$clog2(NUM_SRC)-1:0] win_id,
    output logic [PB-1:0]              win_grp
);
    localparam int IDW = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0][PB-1:0] grp_v;
    logic [NUM_SRC-1:0]         elig_v;
    logic [PB-1:0]              best;

    function automatic logic [PB-1:0] grp_of(input logic [PB-1:0] p, input logic [2:0] g);
        int k;
        k = (int'(g) >= PB) ? PB : int'(g);
        return p & ({PB{1'b1}} << (PB - k));
    endfunction

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            grp_v[i]  = grp_of(prio_i[i], group_i);
            elig_v[i] = gate_i && en_i[i] && pend_i[i]
                     && !(mask_i != '0 && prio_i[i] >= mask_i)
                     && !(act_valid_i && grp_v[i] >= act_grp_i);
        end
    end

    // ascending scan with strict compare: ties keep the lowest index
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_grp   = '0;
        best      = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig_v[i] && (!win_valid || prio_i[i] < best)) begin
                win_valid = 1'b1;
                win_id    = IDW'(i);
                win_grp   = grp_v[i];
                best      = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/pvic_stack.sv
module pvic_stack #(
    parameter int PB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [PB-1:0] push_grp,
    output logic          top_valid,
    output logic [PB-1:0] top_grp
);
    localparam int DEPTH = 1 << PB;
    localparam int SPW   = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][PB-1:0] stk_q;
    logic [SPW-1:0]           sp_q, sp_mid;
    logic [PB-1:0]            top_idx;

    assign sp_mid    = (pop && sp_q != '0) ? sp_q - 1'b1 : sp_q;
    assign top_idx   = PB'(sp_q - 1'b1);
    assign top_valid = sp_q != '0;
    assign top_grp   = stk_q[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            stk_q <= '0;
        end else if (push) begin
            stk_q[sp_mid[PB-1:0]] <= push_grp;
            sp_q <= sp_mid + 1'b1;
        end else begin
            sp_q <= sp_mid;
        end
    end

    // R10: every push nests strictly inside the current level
    a_r10_push_nests: assert property (@(posedge clk) disable iff (!rst_n)
        (push && top_valid && !pop) |-> (push_grp < top_grp));
    // R11: distinct group values bound the depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (sp_mid != SPW'(DEPTH)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pvic_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int PRIO_BITS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [6:0]                 reg_addr,
    input  logic [31:0]                reg_wdata,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    output logic [31:0]                reg_rdata,
    input  logic [NUM_SRC-1:0]         src_irq,
    output logic                       irq_req,
    output logic [$clog2(NUM_SRC)-1:0] irq_id,
    input  logic                       irq_ack,
    input  logic                       irq_eoi
);
    localparam int IDW = $clog2(NUM_SRC);

    ctl_state_t                        state_q, state_d;
    logic [IDW-1:0]                    id_q;
    logic                              take;
    logic [NUM_SRC-1:0]                en_w, pend_w;
    logic [NUM_SRC-1:0][PRIO_BITS-1:0] prio_w;
    logic [2:0]                        group_w;
    logic [PRIO_BITS-1:0]              mask_w, act_grp, win_grp;
    logic                              gate_w, act_valid, win_valid;
    logic [IDW-1:0]                    win_id;

    pvic_regs #(.NUM_SRC(NUM_SRC), .PB(PRIO_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .src_irq(src_irq), .ack_clr(take), .ack_id(id_q),
        .en_o(en_w), .pend_o(pend_w), .prio_o(prio_w),
        .group_o(group_w), .mask_o(mask_w), .gate_o(gate_w)
    );

    pvic_arbiter #(.NUM_SRC(NUM_SRC), .PB(PRIO_BITS)) u_arb (
        .en_i(en_w), .pend_i(pend_w), .prio_i(prio_w), .group_i(group_w),
        .mask_i(mask_w), .gate_i(gate_w), .act_valid_i(act_valid),
        .act_grp_i(act_grp), .win_valid(win_valid), .win_id(win_id),
        .win_grp(win_grp)
    );

    pvic_stack #(.PB(PRIO_BITS)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take), .pop(irq_eoi),
        .push_grp(win_grp), .top_valid(act_valid), .top_grp(act_grp)
    );

    // next-state: acceptance only while the offered source is still the winner
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (win_valid) state_d = ST_OFFER;
            ST_OFFER: begin
                if (irq_ack && win_valid && win_id == id_q) begin
                    take    = 1'b1;
                    state_d = ST_SETTLE;
                end else if (!win_valid) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SETTLE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_SETTLE && win_valid && !take) id_q <= win_id;
        end
    end

    assign irq_req = (state_q == ST_OFFER);
    assign irq_id  = id_q;

    // R8: a closed gate removes the request by the next edge
    a_r8_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_w |=> !irq_req);
    // R9: an accepted offer clears its pending bit and drops the request
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && win_valid && win_id == irq_id)
            |=> (!irq_req && !pend_w[$past(irq_id)]));
    // R6: a winner never sits at or beyond an active mask
    a_r6_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && mask_w != '0) |-> (prio_w[win_id] < mask_w));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/100ps
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_wr, reg_rd;
    logic [31:0] reg_rdata;
    logic [63:0] src_irq;
    logic        irq_req;
    logic [5:0]  irq_id;
    logic        irq_ack, irq_eoi;
    int          total = 0;
    int          fails = 0;
    logic        done  = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .src_irq(src_irq), .irq_req(irq_req), .irq_id(irq_id),
        .irq_ack(irq_ack), .irq_eoi(irq_eoi)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        src_irq = '0; irq_ack = 1'b0; irq_eoi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string r, input logic [6:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(r, reg_rdata, exp);
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        @(negedge clk); irq_eoi = 1'b1;
        @(negedge clk); irq_eoi = 1'b0;
    endtask

    task automatic chk_req(input string r, input logic req, input logic [5:0] id);
        chk(r, {31'd0, irq_req}, {31'd0, req});
        if (req) chk(r, {26'd0, irq_id}, {26'd0, id});
    endtask

    task automatic t_reset();
        do_reset();
        chk_req("R1 req idle", 1'b0, 6'd0);
        rd_chk("R1 enables", 7'h00, 32'h0);
        rd_chk("R1 pending", 7'h11, 32'h0);
        rd_chk("R1 gate", 7'h42, 32'h0);
        rd_chk("R1 group", 7'h40, 32'hFA05_0000);
    endtask

    task automatic t_enables();
        do_reset();
        wr(7'h00, 32'h0000_0005);
        rd_chk("R2 set word0", 7'h00, 32'h0000_0005);
        wr(7'h01, 32'h8000_0000);
        rd_chk("R2 src63 via clr bank", 7'h09, 32'h8000_0000);
        wr(7'h08, 32'h0000_0001);
        rd_chk("R2 clear bit0", 7'h00, 32'h0000_0004);
        wr(7'h08, 32'h0000_0000);
        rd_chk("R2 zero write no effect", 7'h00, 32'h0000_0004);
    endtask

    task automatic t_prio();
        do_reset();
        wr(7'h21, 32'hFFE0_3F21);
        rd_chk("R4 lanes top bits only", 7'h21, 32'hE0E0_2020);
        rd_chk("R4 other word untouched", 7'h20, 32'h0);
    endtask

    task automatic t_arb();
        do_reset();
        wr(7'h00, 32'h0000_0028);
        wr(7'h01, 32'h0000_0100);
        wr(7'h20, 32'h4000_0000);
        wr(7'h21, 32'h0000_4000);
        wr(7'h2A, 32'h0000_0020);
        wr(7'h10, 32'h0000_00A8);
        wr(7'h11, 32'h0000_0100);
        wr(7'h42, 32'h1);
        @(negedge clk);
        chk_req("R5 best priority src40", 1'b1, 6'd40);
        wr(7'h19, 32'h0000_0100);
        @(negedge clk);
        chk_req("R5 tie to lowest src3", 1'b1, 6'd3);
        rd_chk("R3 pend set bank", 7'h10, 32'h0000_00A8);
        rd_chk("R3 clear discards src40", 7'h11, 32'h0);
    endtask

    task automatic t_mask();
        do_reset();
        wr(7'h42, 32'h1);
        wr(7'h00, 32'h8);
        wr(7'h20, 32'h4000_0000);
        wr(7'h10, 32'h8);
        @(negedge clk);
        chk_req("R6 unmasked offer", 1'b1, 6'd3);
        wr(7'h41, 32'h40);
        @(negedge clk);
        chk_req("R6 equal level blocked", 1'b0, 6'd0);
        wr(7'h41, 32'h1F);
        @(negedge clk);
        chk_req("R6 zero implemented bits off", 1'b1, 6'd3);
        rd_chk("R6 low bits read 0", 7'h41, 32'h0);
        wr(7'h41, 32'h60);
        @(negedge clk);
        chk_req("R6 higher mask passes", 1'b1, 6'd3);
    endtask

    task automatic t_gate();
        do_reset();
        wr(7'h00, 32'h1);
        wr(7'h10, 32'h1);
        @(negedge clk);
        chk_req("R8 closed gate", 1'b0, 6'd0);
        rd_chk("R8 enable kept", 7'h00, 32'h1);
        rd_chk("R8 pend kept", 7'h10, 32'h1);
        wr(7'h42, 32'h1);
        @(negedge clk);
        chk_req("R8 gate opened", 1'b1, 6'd0);
        wr(7'h42, 32'h0);
        @(negedge clk);
        chk_req("R8 gate closed again", 1'b0, 6'd0);
        rd_chk("R8 pend still set", 7'h10, 32'h1);
    endtask

    task automatic t_line_ack();
        do_reset();
        wr(7'h42, 32'h1);
        wr(7'h00, 32'h0000_0400);
        @(negedge clk); src_irq[10] = 1'b1;
        repeat (2) @(negedge clk);
        chk_req("R3 edge pends src10", 1'b1, 6'd10);
        pulse_ack();
        chk_req("R9 req drops after ack", 1'b0, 6'd0);
        rd_chk("R9 ack cleared pend", 7'h10, 32'h0);
        src_irq[10] = 1'b0;
        @(negedge clk); src_irq[10] = 1'b1;
        repeat (2) @(negedge clk);
        chk_req("R10 equal group waits", 1'b0, 6'd0);
        pulse_eoi();
        @(negedge clk);
        chk_req("R11 offered after eoi", 1'b1, 6'd10);
    endtask

    task automatic t_group();
        do_reset();
        wr(7'h42, 32'h1);
        wr(7'h00, 32'h6);
        wr(7'h20, 32'h0080_A000);
        wr(7'h10, 32'h2);
        @(negedge clk);
        chk_req("R5 src1 offered", 1'b1, 6'd1);
        pulse_ack();
        wr(7'h10, 32'h4);
        @(negedge clk);
        chk_req("R10 grouping 0 never preempts", 1'b0, 6'd0);
        pulse_eoi();
        @(negedge clk);
        chk_req("R11 src2 after eoi", 1'b1, 6'd2);
        pulse_ack();
        pulse_eoi();
        wr(7'h40, 32'h1234_0003);
        rd_chk("R7 wrong key ignored", 7'h40, 32'hFA05_0000);
        wr(7'h40, 32'h05FA_0002);
        rd_chk("R7 keyed write", 7'h40, 32'hFA05_0002);
        wr(7'h10, 32'h2);
        @(negedge clk);
        chk_req("R5 src1 again", 1'b1, 6'd1);
        pulse_ack();
        wr(7'h10, 32'h4);
        @(negedge clk);
        chk_req("R10 sub-priority no preempt", 1'b0, 6'd0);
        pulse_eoi();
        @(negedge clk);
        chk_req("R11 src2 released", 1'b1, 6'd2);
        pulse_ack();
        wr(7'h00, 32'h8);
        wr(7'h20, 32'h6080_A000);
        wr(7'h40, 32'h05FA_0007);
        wr(7'h10, 32'h8);
        @(negedge clk);
        chk_req("R10 grouping 7 preempts", 1'b1, 6'd3);
        pulse_ack();
        pulse_eoi();
        @(negedge clk);
        chk_req("R11 pop leaves nothing", 1'b0, 6'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_enables();
        t_prio();
        t_arb();
        t_mask();
        t_gate();
        t_line_ack();
        t_group();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule